// File: doc/BRIEF.md
# Three-Format RISC Instruction Decoder

This block turns one 32-bit instruction word into the field values and datapath control signals an execute stage needs. It pulls out the two source register numbers, the shift count and the 26-bit jump target, and it classifies the word as a register, immediate or jump format. It also builds an extended immediate and the full set of steering controls: register write enable and destination, ALU operation and operand source, memory read, write and byte size, branch kind, jump kind and link.

The decode logic is combinational. All of its results are captured in one output register, so every output reflects the word presented at the previous rising clock edge. An opcode or function code the block does not recognise raises an illegal flag and leaves the instruction inert. The word then writes nothing, touches no memory and does not redirect the program counter.

Top module: `riscdec_top`

## Requirements
- R1: All outputs are registered. They show the decode of the `instr_i` value sampled at the previous rising edge. While `rst_n` is low, every output is zero.
- R2: `src_a_o` = word[25:21], `src_b_o` = word[20:16], `shift_o` = word[10:6] and `target_o` = word[25:0]. These hold for every word, including illegal ones.
- R3: `fmt_o` is 0 when opcode word[31:26] is 0. It is 2 for opcodes 2 and 3. It is 1 for every other opcode.
- R4: With opcode 0, the function code word[5:0] selects the ALU code: 32 add→0, 34 sub→1, 36 and→2, 37 or→3, 38 xor→4, 39 nor→5, 0 sll→6, 2 srl→7, 42 slt→8. Immediate opcodes use: 8 addi→0, 10 slti→8, 12 andi→2, 13 ori→3, 15 lui→9. `alu_src_imm_o` is 1 exactly for the immediate ALU, load and store opcodes.
- R5: For instructions that write a register, `dst_sel_o`/`dst_o` are chosen as follows. Opcode-0 writers use code 0 and word[15:11]. Immediate ALU ops and loads use code 1 and word[20:16]. Jump-and-link (opcode 3) uses code 2 and register 31. For instructions that do not write, both are 0.
- R6: `reg_we_o` is 1 only when the instruction writes a register and its destination is not register 0.
- R7: `imm_o` is word[15:0] sign-extended for addi, slti, loads, stores and branches. It is zero-extended for andi and ori. It is 0 for opcode-0, jump and illegal words.
- R8: lui (opcode 15) gives `imm_o` = word[15:0] followed by 16 zero bits, ALU code 9, and a write to word[20:16].
- R9: Loads: opcode 35 (word) and opcode 32 (byte) set `mem_rd_o`. Stores: opcode 43 (word) and opcode 40 (byte) set `mem_wr_o`. `mem_byte_o` marks the byte forms. Stores never write a register.
- R10: beq (opcode 4) gives `branch_o`=1 and bne (opcode 5) gives `branch_o`=2. Both use ALU code 1 and write no register.
- R11: `jump_o` is 1 for opcodes 2 and 3. It is 2 for function codes 8 (jr) and 9 (jalr) under opcode 0. `link_o` is set for opcode 3 and for jalr, and jalr writes its link into word[15:11].
- R12: An unrecognised opcode or opcode-0 function code sets `illegal_o`. In that case every control output, `dst_o` and `imm_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word to decode |
| fmt_o | output | 2 | Format class: 0 register, 1 immediate, 2 jump |
| src_a_o | output | 5 | First source register number |
| src_b_o | output | 5 | Second source register number |
| dst_o | output | 5 | Selected destination register |
| shift_o | output | 5 | Shift count field |
| imm_o | output | 32 | Extended immediate |
| target_o | output | 26 | Jump target field |
| reg_we_o | output | 1 | Register write enable |
| dst_sel_o | output | 2 | Destination source: 0 word[15:11], 1 word[20:16], 2 link |
| alu_op_o | output | 4 | ALU operation code |
| alu_src_imm_o | output | 1 | Second ALU operand is the immediate |
| mem_rd_o | output | 1 | Memory load |
| mem_wr_o | output | 1 | Memory store |
| mem_byte_o | output | 1 | Byte-sized access |
| branch_o | output | 2 | Branch kind: 0 none, 1 equal, 2 not equal |
| jump_o | output | 2 | Jump kind: 0 none, 1 target, 2 register |
| link_o | output | 1 | Return address is written |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
The bench aims at the extension corners: negative offsets, all-ones and top-bit-set 16-bit fields under sign and zero extension, and lui. A mixed-up extension rule would show as wrong upper immediate bits. It drives writes aimed at register 0, including lui and add forms, where a missing suppression would corrupt the hard-wired zero register. It also checks that jalr takes its link from word[15:11] while jal is forced to 31. Unused opcodes and function codes are swept, so a decoder that let an unknown word fire any write, memory access or jump would be caught.

// File: rtl/riscdec_pkg.sv
package riscdec_pkg;

    localparam int INSTR_W = 32;
    localparam int REG_W   = 5;
    localparam int DATA_W  = 32;
    localparam int OP_W    = 6;
    localparam int FN_W    = 6;
    localparam int TGT_W   = 26;
    localparam int IMM_W   = 16;

    typedef enum logic [1:0] {FMT_REG = 2'd0, FMT_IMM = 2'd1, FMT_JMP = 2'd2} fmt_e;
    typedef enum logic [1:0] {DSEL_RD = 2'd0, DSEL_RT = 2'd1, DSEL_LINK = 2'd2} dsel_e;
    typedef enum logic [3:0] {
        ALU_ADD = 4'd0, ALU_SUB = 4'd1, ALU_AND = 4'd2, ALU_OR  = 4'd3,
        ALU_XOR = 4'd4, ALU_NOR = 4'd5, ALU_SLL = 4'd6, ALU_SRL = 4'd7,
        ALU_SLT = 4'd8, ALU_PASSB = 4'd9
    } alu_e;
    typedef enum logic [1:0] {BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2} br_e;
    typedef enum logic [1:0] {JMP_NONE = 2'd0, JMP_TGT = 2'd1, JMP_REG = 2'd2} jmp_e;
    typedef enum logic [1:0] {IMMK_NONE, IMMK_SEXT, IMMK_ZEXT, IMMK_UPPER} immk_e;

    localparam logic [OP_W-1:0] OPC_REG  = 6'd0;
    localparam logic [OP_W-1:0] OPC_J    = 6'd2;
    localparam logic [OP_W-1:0] OPC_JAL  = 6'd3;
    localparam logic [OP_W-1:0] OPC_BEQ  = 6'd4;
    localparam logic [OP_W-1:0] OPC_BNE  = 6'd5;
    localparam logic [OP_W-1:0] OPC_ADDI = 6'd8;
    localparam logic [OP_W-1:0] OPC_SLTI = 6'd10;
    localparam logic [OP_W-1:0] OPC_ANDI = 6'd12;
    localparam logic [OP_W-1:0] OPC_ORI  = 6'd13;
    localparam logic [OP_W-1:0] OPC_LUI  = 6'd15;
    localparam logic [OP_W-1:0] OPC_LB   = 6'd32;
    localparam logic [OP_W-1:0] OPC_LW   = 6'd35;
    localparam logic [OP_W-1:0] OPC_SB   = 6'd40;
    localparam logic [OP_W-1:0] OPC_SW   = 6'd43;

    localparam logic [FN_W-1:0] FN_SLL  = 6'd0;
    localparam logic [FN_W-1:0] FN_SRL  = 6'd2;
    localparam logic [FN_W-1:0] FN_JR   = 6'd8;
    localparam logic [FN_W-1:0] FN_JALR = 6'd9;
    localparam logic [FN_W-1:0] FN_ADD  = 6'd32;
    localparam logic [FN_W-1:0] FN_SUB  = 6'd34;
    localparam logic [FN_W-1:0] FN_AND  = 6'd36;
    localparam logic [FN_W-1:0] FN_OR   = 6'd37;
    localparam logic [FN_W-1:0] FN_XOR  = 6'd38;
    localparam logic [FN_W-1:0] FN_NOR  = 6'd39;
    localparam logic [FN_W-1:0] FN_SLT  = 6'd42;

    typedef struct packed {
        logic  legal;
        logic  writes;
        dsel_e dsel;
        alu_e  alu;
        logic  alu_imm;
        logic  mrd;
        logic  mwr;
        logic  mbyte;
        br_e   br;
        jmp_e  jmp;
        logic  link;
        immk_e immk;
    } ctrl_t;

    typedef struct packed {
        fmt_e              fmt;
        logic [REG_W-1:0]  src_a;
        logic [REG_W-1:0]  src_b;
        logic [REG_W-1:0]  dst;
        logic [REG_W-1:0]  shift;
        logic [DATA_W-1:0] imm;
        logic [TGT_W-1:0]  target;
        logic              we;
        dsel_e             dsel;
        alu_e              alu;
        logic              alu_imm;
        logic              mrd;
        logic              mwr;
        logic              mbyte;
        br_e               br;
        jmp_e              jmp;
        logic              link;
        logic              illegal;
    } out_t;

endpackage

// File: rtl/riscdec_fields.sv
module riscdec_fields
    import riscdec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [OP_W-1:0]    op,
    output logic [FN_W-1:0]    fn,
    output logic [REG_W-1:0]   fa,
    output logic [REG_W-1:0]   fb,
    output logic [REG_W-1:0]   fd,
    output logic [REG_W-1:0]   sh,
    output logic [IMM_W-1:0]   imm16,
    output logic [TGT_W-1:0]   tgt
);
    localparam int OP_LO = INSTR_W - OP_W;
    localparam int FA_LO = OP_LO - REG_W;
    localparam int FB_LO = FA_LO - REG_W;
    localparam int FD_LO = FB_LO - REG_W;
    localparam int SH_LO = FD_LO - REG_W;

    always_comb begin
        op    = instr[INSTR_W-1:OP_LO];
        fa    = instr[OP_LO-1:FA_LO];
        fb    = instr[FA_LO-1:FB_LO];
        fd    = instr[FB_LO-1:FD_LO];
        sh    = instr[FD_LO-1:SH_LO];
        fn    = instr[FN_W-1:0];
        imm16 = instr[IMM_W-1:0];
        tgt   = instr[TGT_W-1:0];
    end
endmodule

// File: rtl/riscdec_ctrl.sv
module riscdec_ctrl
    import riscdec_pkg::*;
(
    input  logic [OP_W-1:0] op,
    input  logic [FN_W-1:0] fn,
    output ctrl_t           ctl,
    output fmt_e            fmt
);
    always_comb begin
        ctl       = '0;
        ctl.legal = 1'b1;
        case (op)
            OPC_REG, OPC_J, OPC_JAL: fmt = (op == OPC_REG) ? FMT_REG : FMT_JMP;
            default:                 fmt = FMT_IMM;
        endcase

        case (op)
            OPC_REG: begin
                ctl.writes = 1'b1;
                case (fn)
                    FN_ADD:  ctl.alu = ALU_ADD;
                    FN_SUB:  ctl.alu = ALU_SUB;
                    FN_AND:  ctl.alu = ALU_AND;
                    FN_OR:   ctl.alu = ALU_OR;
                    FN_XOR:  ctl.alu = ALU_XOR;
                    FN_NOR:  ctl.alu = ALU_NOR;
                    FN_SLL:  ctl.alu = ALU_SLL;
                    FN_SRL:  ctl.alu = ALU_SRL;
                    FN_SLT:  ctl.alu = ALU_SLT;
                    FN_JR: begin
                        ctl.writes = 1'b0;
                        ctl.jmp    = JMP_REG;
                    end
                    FN_JALR: begin
                        ctl.jmp  = JMP_REG;
                        ctl.link = 1'b1;
                    end
                    default: ctl.legal = 1'b0;
                endcase
            end
            OPC_J:   ctl.jmp = JMP_TGT;
            OPC_JAL: begin
                ctl.jmp    = JMP_TGT;
                ctl.link   = 1'b1;
                ctl.writes = 1'b1;
                ctl.dsel   = DSEL_LINK;
            end
            OPC_BEQ, OPC_BNE: begin
                ctl.br   = (op == OPC_BEQ) ? BR_EQ : BR_NE;
                ctl.alu  = ALU_SUB;
                ctl.immk = IMMK_SEXT;
            end
            OPC_ADDI, OPC_SLTI, OPC_ANDI, OPC_ORI, OPC_LUI: begin
                ctl.writes  = 1'b1;
                ctl.dsel    = DSEL_RT;
                ctl.alu_imm = 1'b1;
                case (op)
                    OPC_ADDI: begin ctl.alu = ALU_ADD;   ctl.immk = IMMK_SEXT;  end
                    OPC_SLTI: begin ctl.alu = ALU_SLT;   ctl.immk = IMMK_SEXT;  end
                    OPC_ANDI: begin ctl.alu = ALU_AND;   ctl.immk = IMMK_ZEXT;  end
                    OPC_ORI:  begin ctl.alu = ALU_OR;    ctl.immk = IMMK_ZEXT;  end
                    default:  begin ctl.alu = ALU_PASSB; ctl.immk = IMMK_UPPER; end
                endcase
            end
            OPC_LB, OPC_LW: begin
                ctl.writes  = 1'b1;
                ctl.dsel    = DSEL_RT;
                ctl.alu_imm = 1'b1;
                ctl.immk    = IMMK_SEXT;
                ctl.mrd     = 1'b1;
                ctl.mbyte   = (op == OPC_LB);
            end
            OPC_SB, OPC_SW: begin
                ctl.alu_imm = 1'b1;
                ctl.immk    = IMMK_SEXT;
                ctl.mwr     = 1'b1;
                ctl.mbyte   = (op == OPC_SB);
            end
            default: ctl.legal = 1'b0;
        endcase

        if (!ctl.legal) begin
            ctl       = '0;
            ctl.legal = 1'b0;
        end
    end
endmodule

// File: rtl/riscdec_imm.sv
module riscdec_imm
    import riscdec_pkg::*;
(
    input  logic [IMM_W-1:0]  raw,
    input  immk_e             kind,
    output logic [DATA_W-1:0] value
);
    localparam int UP_W = 2 * IMM_W;

    always_comb begin
        case (kind)
            IMMK_SEXT:  value = DATA_W'($signed(raw));
            IMMK_ZEXT:  value = DATA_W'(raw);
            IMMK_UPPER: value = DATA_W'($signed({raw, {IMM_W{1'b0}}} & {UP_W{1'b1}}));
            default:    value = '0;
        endcase
    end
endmodule

// File: rtl/riscdec_top.sv
module riscdec_top
    import riscdec_pkg::*;
#(
    parameter int LINK_REG = 31
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [31:0]        instr_i,
    output logic [1:0]         fmt_o,
    output logic [4:0]         src_a_o,
    output logic [4:0]         src_b_o,
    output logic [4:0]         dst_o,
    output logic [4:0]         shift_o,
    output logic [31:0]        imm_o,
    output logic [25:0]        target_o,
    output logic               reg_we_o,
    output logic [1:0]         dst_sel_o,
    output logic [3:0]         alu_op_o,
    output logic               alu_src_imm_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic               mem_byte_o,
    output logic [1:0]         branch_o,
    output logic [1:0]         jump_o,
    output logic               link_o,
    output logic               illegal_o
);
    logic [OP_W-1:0]   op;
    logic [FN_W-1:0]   fn;
    logic [REG_W-1:0]  fa, fb, fd, sh;
    logic [IMM_W-1:0]  imm16;
    logic [TGT_W-1:0]  tgt;
    ctrl_t             ctl;
    fmt_e              fmt;
    logic [DATA_W-1:0] imm_ext;
    logic [REG_W-1:0]  dst_pick;
    out_t              out_d, out_q;

    riscdec_fields u_fields (
        .instr (instr_i), .op (op), .fn (fn), .fa (fa), .fb (fb),
        .fd (fd), .sh (sh), .imm16 (imm16), .tgt (tgt)
    );

    riscdec_ctrl u_ctrl (.op (op), .fn (fn), .ctl (ctl), .fmt (fmt));

    riscdec_imm u_imm (.raw (imm16), .kind (ctl.immk), .value (imm_ext));

    always_comb begin
        case (ctl.dsel)
            DSEL_RT:   dst_pick = fb;
            DSEL_LINK: dst_pick = REG_W'(LINK_REG);
            default:   dst_pick = fd;
        endcase

        out_d         = '0;
        out_d.fmt     = fmt;
        out_d.src_a   = fa;
        out_d.src_b   = fb;
        out_d.shift   = sh;
        out_d.target  = tgt;
        out_d.illegal = !ctl.legal;
        if (ctl.legal) begin
            out_d.imm     = imm_ext;
            out_d.dst     = ctl.writes ? dst_pick : '0;
            out_d.we      = ctl.writes && (dst_pick != '0);
            out_d.dsel    = ctl.dsel;
            out_d.alu     = ctl.alu;
            out_d.alu_imm = ctl.alu_imm;
            out_d.mrd     = ctl.mrd;
            out_d.mwr     = ctl.mwr;
            out_d.mbyte   = ctl.mbyte;
            out_d.br      = ctl.br;
            out_d.jmp     = ctl.jmp;
            out_d.link    = ctl.link;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    always_comb begin
        fmt_o         = out_q.fmt;
        src_a_o       = out_q.src_a;
        src_b_o       = out_q.src_b;
        dst_o         = out_q.dst;
        shift_o       = out_q.shift;
        imm_o         = out_q.imm;
        target_o      = out_q.target;
        reg_we_o      = out_q.we;
        dst_sel_o     = out_q.dsel;
        alu_op_o      = out_q.alu;
        alu_src_imm_o = out_q.alu_imm;
        mem_rd_o      = out_q.mrd;
        mem_wr_o      = out_q.mwr;
        mem_byte_o    = out_q.mbyte;
        branch_o      = out_q.br;
        jump_o        = out_q.jmp;
        link_o        = out_q.link;
        illegal_o     = out_q.illegal;
    end
endmodule

// File: rtl/riscdec_chk.sv
module riscdec_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] instr_i,
    input logic [1:0]  fmt_o,
    input logic [4:0]  src_a_o,
    input logic [4:0]  dst_o,
    input logic [31:0] imm_o,
    input logic        reg_we_o,
    input logic        mem_rd_o,
    input logic        mem_wr_o,
    input logic [1:0]  branch_o,
    input logic [1:0]  jump_o,
    input logic        link_o,
    input logic        illegal_o
);
    p_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (src_a_o == $past(instr_i[25:21])));

    p_reg_fmt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:26] == 6'd0) |=> (fmt_o == 2'd0));

    p_zero_dst_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we_o |-> (dst_o != 5'd0));

    p_lui_low_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:26] == 6'd15) |=> (imm_o == {$past(instr_i[15:0]), 16'h0000}));

    p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd_o, mem_wr_o, branch_o != 2'd0, jump_o != 2'd0}));

    p_store_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_o |-> !reg_we_o);

    p_jal_link_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_i[31:26] == 6'd3) |=> (reg_we_o && link_o && dst_o == 5'd31));

    p_illegal_inert_r12: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (!reg_we_o && !mem_rd_o && !mem_wr_o && branch_o == 2'd0
                       && jump_o == 2'd0 && !link_o));
endmodule

bind riscdec_top riscdec_chk u_chk (.*);

// File: tb/riscdec_top_test.sv
`timescale 1ns/1ps
module riscdec_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr_i = '0;
    logic [1:0]  fmt_o, dst_sel_o, branch_o, jump_o;
    logic [4:0]  src_a_o, src_b_o, dst_o, shift_o;
    logic [31:0] imm_o;
    logic [25:0] target_o;
    logic [3:0]  alu_op_o;
    logic reg_we_o, alu_src_imm_o, mem_rd_o, mem_wr_o, mem_byte_o, link_o, illegal_o;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    riscdec_top uut (.*);

    function automatic logic [96:0] model(input logic [31:0] w);
        int op = w[31:26], fn = w[5:0];
        int fmt, ds = 0, alu = 0, br = 0, jp = 0, ik = 0;
        bit legal = 1, wr = 0, ai = 0, mr = 0, mw = 0, mb = 0, lk = 0, we;
        logic [4:0] dnum, dst;
        logic [31:0] imm;
        fmt = (op == 0) ? 0 : (op == 2 || op == 3) ? 2 : 1;
        case (op)
            0: begin
                wr = 1;
                case (fn)
                    32: alu = 0; 34: alu = 1; 36: alu = 2; 37: alu = 3;
                    38: alu = 4; 39: alu = 5; 0: alu = 6; 2: alu = 7; 42: alu = 8;
                    8: begin wr = 0; jp = 2; end
                    9: begin jp = 2; lk = 1; end
                    default: legal = 0;
                endcase
            end
            2: jp = 1;
            3: begin jp = 1; lk = 1; wr = 1; ds = 2; end
            4: begin br = 1; alu = 1; ik = 1; end
            5: begin br = 2; alu = 1; ik = 1; end
            8:  begin wr = 1; ds = 1; ai = 1; ik = 1; alu = 0; end
            10: begin wr = 1; ds = 1; ai = 1; ik = 1; alu = 8; end
            12: begin wr = 1; ds = 1; ai = 1; ik = 2; alu = 2; end
            13: begin wr = 1; ds = 1; ai = 1; ik = 2; alu = 3; end
            15: begin wr = 1; ds = 1; ai = 1; ik = 3; alu = 9; end
            32, 35: begin wr = 1; ds = 1; ai = 1; ik = 1; mr = 1; mb = (op == 32); end
            40, 43: begin ai = 1; ik = 1; mw = 1; mb = (op == 40); end
            default: legal = 0;
        endcase
        case (ik)
            1: imm = {{16{w[15]}}, w[15:0]};
            2: imm = {16'h0, w[15:0]};
            3: imm = {w[15:0], 16'h0};
            default: imm = 0;
        endcase
        dnum = (ds == 0) ? w[15:11] : (ds == 1) ? w[20:16] : 5'd31;
        dst = wr ? dnum : 5'd0;
        we = wr && (dnum != 0);
        if (!legal) begin
            wr = 0; ds = 0; alu = 0; ai = 0; mr = 0; mw = 0; mb = 0;
            br = 0; jp = 0; lk = 0; imm = 0; dst = 0; we = 0;
        end
        return {2'(fmt), w[25:21], w[20:16], dst, w[10:6], imm, w[25:0], we, 2'(ds),
                4'(alu), ai, mr, mw, mb, 2'(br), 2'(jp), lk, !legal};
    endfunction

    function automatic logic [96:0] actual();
        return {fmt_o, src_a_o, src_b_o, dst_o, shift_o, imm_o, target_o, reg_we_o,
                dst_sel_o, alu_op_o, alu_src_imm_o, mem_rd_o, mem_wr_o, mem_byte_o,
                branch_o, jump_o, link_o, illegal_o};
    endfunction

    task automatic check(input string tag, input logic [96:0] exp);
        checks++;
        if (actual() !== exp) begin
            errors++;
            $display("FAIL %s: instr=%h actual=%h expected=%h", tag, instr_i, actual(), exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input string tag);
        @(negedge clk);
        instr_i = w;
        @(negedge clk);
        check(tag, model(w));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [5:0] ops [14] = '{0, 2, 3, 4, 5, 8, 10, 12, 13, 15, 32, 35, 40, 43};
        instr_i = 32'h8C450BB8;
        repeat (3) @(negedge clk);
        check("R1 reset", 97'd0);
        rst_n = 1'b1;

        apply(32'h00622020, "R4 add");
        apply(32'h00620020, "R6 add to reg0");
        apply(32'h000519C0, "R2 sll");
        apply(32'h8C450BB8, "R9 lw");
        apply(32'hAC450BB8, "R9 sw");
        apply(32'h80458004, "R9 lb negative");
        apply(32'hA0450004, "R9 sb");
        apply(32'h1009000A, "R10 beq");
        apply(32'h1445FFFE, "R10 bne");
        apply(32'h0C10000C, "R11 jal");
        apply(32'h08000010, "R11 j");
        apply(32'h0040F809, "R11 jalr");
        apply(32'h00401809, "R11 jalr rd3");
        apply(32'h00400008, "R11 jr");
        apply(32'h2045FFFF, "R7 addi neg");
        apply(32'h28458000, "R7 slti");
        apply(32'h3045FFFF, "R7 andi");
        apply(32'h34458000, "R7 ori");
        apply(32'h3C05ABCD, "R8 lui");
        apply(32'h3C001234, "R6 lui to reg0");
        apply(32'hFC000000, "R12 bad opcode");
        apply(32'h00622021, "R12 bad funct");
        apply(32'h7C000000, "R3 bad opcode fmt");

        @(negedge clk);
        instr_i = 32'h3C05ABCD;
        #1 check("R1 latency", model(32'h7C000000));
        @(negedge clk);
        check("R1 latency", model(32'h3C05ABCD));

        for (int f = 0; f < 64; f++)
            apply({6'd0, 5'd7, 5'd9, 5'd11, 5'd13, 6'(f)}, "R4 funct sweep");
        for (int o = 0; o < 64; o++)
            apply({6'(o), 26'h2A5B3C7}, "R3 opcode sweep");
        for (int i = 0; i < 400; i++) begin
            logic [31:0] w = $urandom;
            if (i % 2 == 0) w[31:26] = ops[$urandom_range(13)];
            apply(w, "R5 random");
        end
        finish_run();
    end
endmodule